// File: doc/BRIEF.md
# Reed-Solomon Encoder with Selectable First Root

This block is a systematic Reed-Solomon encoder over GF(2^m). Its generator polynomial has 2t consecutive roots, and the lowest of them is a run-time choice α^h rather than the usual α^1. A single fixed encoder sits at the centre. That encoder divides by the polynomial with roots α^1..α^2t. Two scaling stages surround it. The input stage multiplies symbol i of the block by α^(-(h-1)·i). The output stage multiplies emitted symbol i by α^((h-1)·i). Each stage holds its own running power register. The scaling cancels on the information symbols, and it moves the roots of the code to α^h..α^(h+2t-1).

Symbols arrive on a valid/ready stream. A start-of-block flag marks the first information symbol, and the root selector is captured together with that symbol. After k information symbols the block stops accepting input for 2t cycles while it sends out the parity. The default code is RS(7,5) over GF(8), built on the primitive polynomial x^3 + x + 1.

Top module: `rsp_encoder`

## Requirements
- R1: With n = 2^m − 1 and k = n − 2t, each block accepts exactly k information symbols and emits n symbols: first the k information symbols, then the 2t parity symbols. `out_last` is high only with the n-th symbol.
- R2: `in_ready` is low for exactly 2t consecutive cycles per block, while parity is emitted. It is high at all other times.
- R3: Every accepted information symbol appears on the output with `out_valid` high one clock after the edge that accepted it.
- R4: The first k output symbols of a block equal the accepted input symbols, in order.
- R5: Read the emitted codeword as a polynomial whose first emitted symbol is the coefficient of x^(n−1). That polynomial is zero at α^h, α^(h+1), …, α^(h+2t−1) for every h from 0 to n−1. Here α is the field element with value 2, and the default field is built on x^3 + x + 1, which is value 4'b1011.
- R6: With h = 1 the parity symbols equal the remainder of d(x)·x^2t divided by (x−α)(x−α^2)…(x−α^2t), with the highest-degree coefficient emitted first.
- R7: `h_sel` is sampled only on the accepted symbol that carries `in_sob`. Changing it later in the block does not affect the codeword.
- R8: A symbol that is offered while no block is open and that does not carry `in_sob` is discarded and produces no output.
- R9: `in_sob` on a symbol inside an open block is ignored, and that symbol is encoded as ordinary data.
- R10: A synchronous active-high reset drops any open block and leaves `out_valid` low and `in_ready` high. The next block after reset is encoded correctly.
- R11: Root exponents are taken modulo n, so `h_sel` = n (all ones) gives the same codeword as `h_sel` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input symbol offered |
| in_ready | output | 1 | Block can take an input symbol |
| in_sob | input | 1 | Offered symbol is the first of a block |
| in_sym | input | m | Information symbol |
| h_sel | input | m | Exponent of the lowest generator root |
| out_valid | output | 1 | Output symbol valid |
| out_sym | output | m | Codeword symbol |
| out_last | output | 1 | Output symbol is the last of the codeword |

## Verification
The table of blocks covers every root selector from 0 to n−1, plus the out-of-range value n. The messages include all-zero data, all-ones data, a single non-zero symbol and dense mixed symbols, so any error in the scaling or in the feedback taps shows up in a non-zero syndrome. For h = 1 the parity is compared exactly against a long division, which separates a wrong root set from a wrong generator. Alternate blocks leave gaps in `in_valid` to show that the running powers advance per accepted symbol and not per cycle. Directed blocks change `h_sel` in mid-block, raise a stray `in_sob`, offer idle symbols without a start flag, and reset in the middle of a block.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

    localparam int GF_MAXW = 16;

    typedef logic [GF_MAXW-1:0] gf_word_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_PARITY
    } enc_state_e;

    typedef struct packed {
        logic valid;
        logic last;
    } out_ctl_t;

    // Shift-and-add product in GF(2^m); poly includes the x^m term.
    function automatic gf_word_t gf_mul(input gf_word_t a, input gf_word_t b,
                                        input gf_word_t poly, input int m);
        gf_word_t acc;
        gf_word_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < GF_MAXW; i++) begin
            if (i < m) begin
                if (b[i]) acc = acc ^ sh;
                sh = sh << 1;
                if (sh[m]) sh = sh ^ poly;
            end
        end
        return acc;
    endfunction

    // base^e by square-and-multiply over the m exponent bits.
    function automatic gf_word_t gf_pow(input gf_word_t base, input gf_word_t e,
                                        input gf_word_t poly, input int m);
        gf_word_t res;
        gf_word_t b;
        res = gf_word_t'(1);
        b   = base;
        for (int i = 0; i < GF_MAXW; i++) begin
            if (i < m) begin
                if (e[i]) res = gf_mul(res, b, poly, m);
                b = gf_mul(b, b, poly, m);
            end
        end
        return res;
    endfunction

    // Coefficient idx (of x^idx) of prod_{r=1..nroots} (x + alpha^r).
    function automatic gf_word_t gen_coef(input int idx, input int nroots,
                                          input gf_word_t poly, input int m);
        gf_word_t c [64];
        gf_word_t root;
        for (int i = 0; i < 64; i++) c[i] = '0;
        c[0] = gf_word_t'(1);
        root = gf_word_t'(2);
        for (int r = 0; r < nroots; r++) begin
            for (int i = 63; i >= 1; i--) c[i] = c[i-1] ^ gf_mul(c[i], root, poly, m);
            c[0] = gf_mul(c[0], root, poly, m);
            root = gf_mul(root, gf_word_t'(2), poly, m);
        end
        return c[idx];
    endfunction

endpackage

// File: rtl/rsp_scale.sv
module rsp_scale import rsp_pkg::*; #(
    parameter int         M         = 3,
    parameter logic [M:0] PRIM_POLY = 4'b1011
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [M-1:0] step_in,
    input  logic         adv,
    input  logic [M-1:0] sym_in,
    output logic [M-1:0] sym_out,
    output logic [M-1:0] pow_o
);

    localparam gf_word_t POLY_W = gf_word_t'(PRIM_POLY);

    function automatic logic [M-1:0] fmul(input logic [M-1:0] a, input logic [M-1:0] b);
        gf_word_t r;
        r = gf_mul(gf_word_t'(a), gf_word_t'(b), POLY_W, M);
        return r[M-1:0];
    endfunction

    logic [M-1:0] pow_q, step_q;
    logic [M-1:0] cur_pow, cur_step;

    // Symbol 0 of a block always sees power 1.
    assign cur_pow  = start ? M'(1) : pow_q;
    assign cur_step = start ? step_in : step_q;
    assign sym_out  = fmul(sym_in, cur_pow);
    assign pow_o    = pow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pow_q  <= M'(1);
            step_q <= M'(1);
        end else begin
            if (start) step_q <= step_in;
            if (adv)        pow_q <= fmul(cur_pow, cur_step);
            else if (start) pow_q <= M'(1);
        end
    end

    assert_pow_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
        pow_q != '0);

endmodule

// File: rtl/rsp_lfsr.sv
module rsp_lfsr import rsp_pkg::*; #(
    parameter int         M         = 3,
    parameter int         T2        = 2,
    parameter logic [M:0] PRIM_POLY = 4'b1011
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         feed,
    input  logic         drain,
    input  logic [M-1:0] din,
    output logic [M-1:0] par_out
);

    localparam gf_word_t POLY_W = gf_word_t'(PRIM_POLY);

    function automatic logic [M-1:0] fmul(input logic [M-1:0] a, input logic [M-1:0] b);
        gf_word_t r;
        r = gf_mul(gf_word_t'(a), gf_word_t'(b), POLY_W, M);
        return r[M-1:0];
    endfunction

    logic [T2-1:0][M-1:0] gco;
    logic [T2-1:0][M-1:0] r_q, nxt;
    logic [M-1:0]         fb;

    for (genvar j = 0; j < T2; j++) begin : g_coef
        localparam gf_word_t GW = gen_coef(j, T2, POLY_W, M);
        assign gco[j] = GW[M-1:0];
    end

    assign fb      = din ^ r_q[T2-1];
    assign par_out = r_q[T2-1];

    always_comb begin
        nxt[0] = feed ? fmul(fb, gco[0]) : '0;
        for (int j = 1; j < T2; j++)
            nxt[j] = r_q[j-1] ^ (feed ? fmul(fb, gco[j]) : '0);
    end

    always_ff @(posedge clk) begin
        if (rst)                r_q <= '0;
        else if (feed || drain) r_q <= nxt;
    end

    assert_feed_drain_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(feed && drain));

endmodule

// File: rtl/rsp_encoder.sv
module rsp_encoder import rsp_pkg::*; #(
    parameter int         M         = 3,
    parameter int         T         = 1,
    parameter logic [M:0] PRIM_POLY = 4'b1011
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic         in_sob,
    input  logic [M-1:0] in_sym,
    input  logic [M-1:0] h_sel,
    output logic         out_valid,
    output logic [M-1:0] out_sym,
    output logic         out_last
);

    localparam int         N      = (1 << M) - 1;
    localparam int         T2     = 2 * T;
    localparam int         K      = N - T2;
    localparam int         CW     = $clog2(N + 1);
    localparam gf_word_t   POLY_W = gf_word_t'(PRIM_POLY);
    localparam logic [M+1:0] NW   = (M+2)'(N);

    function automatic logic [M-1:0] fmul(input logic [M-1:0] a, input logic [M-1:0] b);
        gf_word_t r;
        r = gf_mul(gf_word_t'(a), gf_word_t'(b), POLY_W, M);
        return r[M-1:0];
    endfunction

    enc_state_e    state_q;
    logic [CW-1:0] cnt_q;
    out_ctl_t      ctl_q;
    logic [M-1:0]  sym_q;

    logic fire, start, take, emit_par;
    logic [M+1:0] hsum, e_out_w;
    logic [M-1:0] e_out, e_in, step_fwd, step_bwd;
    gf_word_t     pw_fwd, pw_bwd;
    logic [M-1:0] scaled_in, inner_sym, out_next, lfsr_head;
    logic [M-1:0] pow_in, pow_out;

    assign in_ready = (state_q != ST_PARITY);
    assign fire     = in_valid && in_ready;
    assign start    = fire && (state_q == ST_IDLE) && in_sob;
    assign take     = start || (fire && (state_q == ST_DATA));
    assign emit_par = (state_q == ST_PARITY);

    // Output step alpha^(h-1), input step alpha^-(h-1), exponents mod n.
    always_comb begin
        hsum    = {2'b00, h_sel} + NW - (M+2)'(1);
        e_out_w = (hsum >= NW) ? hsum - NW : hsum;
        e_out   = e_out_w[M-1:0];
        e_in    = (e_out == '0) ? '0 : M'(N) - e_out;
        pw_fwd  = gf_pow(gf_word_t'(2), gf_word_t'(e_out), POLY_W, M);
        pw_bwd  = gf_pow(gf_word_t'(2), gf_word_t'(e_in), POLY_W, M);
        step_fwd = pw_fwd[M-1:0];
        step_bwd = pw_bwd[M-1:0];
    end

    rsp_scale #(.M(M), .PRIM_POLY(PRIM_POLY)) u_scale_in (
        .clk(clk), .rst(rst), .start(start), .step_in(step_bwd), .adv(take),
        .sym_in(in_sym), .sym_out(scaled_in), .pow_o(pow_in)
    );

    rsp_lfsr #(.M(M), .T2(T2), .PRIM_POLY(PRIM_POLY)) u_lfsr (
        .clk(clk), .rst(rst), .feed(take), .drain(emit_par),
        .din(scaled_in), .par_out(lfsr_head)
    );

    assign inner_sym = emit_par ? lfsr_head : scaled_in;

    rsp_scale #(.M(M), .PRIM_POLY(PRIM_POLY)) u_scale_out (
        .clk(clk), .rst(rst), .start(start), .step_in(step_fwd), .adv(take || emit_par),
        .sym_in(inner_sym), .sym_out(out_next), .pow_o(pow_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            ctl_q   <= '0;
            sym_q   <= '0;
        end else begin
            ctl_q.valid <= take || emit_par;
            ctl_q.last  <= emit_par && (cnt_q == CW'(T2 - 1));
            sym_q       <= out_next;
            if (take) begin
                if (cnt_q == CW'(K - 1)) begin
                    state_q <= ST_PARITY;
                    cnt_q   <= '0;
                end else begin
                    state_q <= ST_DATA;
                    cnt_q   <= cnt_q + CW'(1);
                end
            end else if (emit_par) begin
                if (cnt_q == CW'(T2 - 1)) begin
                    state_q <= ST_IDLE;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + CW'(1);
                end
            end
        end
    end

    assign out_valid = ctl_q.valid;
    assign out_last  = ctl_q.last;
    assign out_sym   = sym_q;

    assert_accept_to_out_R3: assert property (@(posedge clk) disable iff (rst)
        take |=> out_valid);

    assert_last_valid_R1: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    assert_ready_after_last_R2: assert property (@(posedge clk) disable iff (rst)
        out_last |-> in_ready);

    // R4: the two stages cancel while information symbols pass.
    assert_scale_inverse_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DATA) |-> (fmul(pow_in, pow_out) == M'(1)));

    assert_lfsr_empty_at_start_R5: assert property (@(posedge clk) disable iff (rst)
        start |-> (lfsr_head == '0));

endmodule

// File: tb/sim_rsp_encoder.sv
`timescale 1ns/1ps
module sim_rsp_encoder;

    localparam int M    = 3;
    localparam int T    = 1;
    localparam int N    = (1 << M) - 1;
    localparam int T2   = 2 * T;
    localparam int K    = N - T2;
    localparam int POLY = 'b1011;
    localparam int NV   = 11;

    // {h, d0, d1, d2, d3, d4}, one octal digit each
    localparam logic [M*(K+1)-1:0] VEC [NV] = '{
        18'o012345, 18'o111111, 18'o100000, 18'o177777, 18'o234567, 18'o300001,
        18'o476543, 18'o555555, 18'o610203, 18'o765432, 18'o600000
    };

    logic clk = 0;
    logic rst = 1;
    logic in_valid = 0, in_sob = 0;
    logic [M-1:0] in_sym = '0, h_sel = '0;
    logic in_ready, out_valid, out_last;
    logic [M-1:0] out_sym;

    int checks = 0, errors = 0;
    bit finished = 0;
    int exp_t [2*N];
    int log_t [N+1];
    int got [N];
    int keep [N];

    always #10 clk = ~clk;

    rsp_encoder #(.M(M), .T(T)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_sob(in_sob),
        .in_sym(in_sym), .h_sel(h_sel), .out_valid(out_valid), .out_sym(out_sym),
        .out_last(out_last)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int fm(input int a, input int b);
        if (a == 0 || b == 0) return 0;
        return exp_t[(log_t[a] + log_t[b]) % N];
    endfunction

    function automatic int dsym(input logic [M*K-1:0] dv, input int i);
        return int'(dv[M*(K-1-i) +: M]);
    endfunction

    task automatic run_block(input int hv, input logic [M*K-1:0] dv, input bit gaps,
                             input bit junk, input bit mid, output int nout,
                             output int nlow, output int fcyc, output bit lastok);
        int sent = 0;
        int cyc = 0;
        bit fin = 0;
        nout = 0; nlow = 0; fcyc = -1; lastok = 1;
        while (!fin && cyc < 60) begin
            @(negedge clk);
            cyc++;
            if (out_valid) begin
                if (nout < N) got[nout] = int'(out_sym);
                if (fcyc < 0) fcyc = cyc;
                nout++;
                if (out_last) begin
                    fin = 1;
                    if (nout != N) lastok = 0;
                end
            end else if (out_last) lastok = 0;
            if (!in_ready) nlow++;
            if (sent < K && !(gaps && (cyc % 2 == 0))) begin
                in_valid = 1;
                in_sym   = M'(dsym(dv, sent));
                in_sob   = (sent == 0) || (mid && sent == 2);
                h_sel    = (sent == 0 || !junk) ? M'(hv) : M'(hv + 3 + sent);
                sent++;
            end else begin
                in_valid = 0;
                in_sob   = 0;
            end
        end
        in_valid = 0;
        in_sob   = 0;
    endtask

    task automatic verify(input int hv, input logic [M*K-1:0] dv, input int nout,
                          input int nlow, input int fcyc, input bit lastok);
        int heff;
        heff = hv % N;
        chk(nout == N, "R1 output count", nout, N);
        chk(lastok, "R1 out_last position", int'(lastok), 1);
        chk(nlow == T2, "R2 ready-low cycles", nlow, T2);
        chk(fcyc == 2, "R3 first output latency", fcyc, 2);
        for (int i = 0; i < K; i++)
            chk(got[i] == dsym(dv, i), "R4 systematic symbol", got[i], dsym(dv, i));
        for (int j = 0; j < T2; j++) begin
            int s = (heff + j) % N;
            int acc = 0;
            for (int i = 0; i < N; i++) acc ^= fm(got[i], exp_t[(s * (N - 1 - i)) % N]);
            chk(acc == 0, "R5 syndrome at alpha^(h+j)", acc, 0);
        end
        if (heff == 1) begin
            int gl [T2+1];
            int c [N];
            for (int i = 0; i <= T2; i++) gl[i] = 0;
            gl[0] = 1;
            for (int r = 1; r <= T2; r++) begin
                for (int i = T2; i >= 1; i--) gl[i] = gl[i-1] ^ fm(gl[i], exp_t[r]);
                gl[0] = fm(gl[0], exp_t[r]);
            end
            for (int i = 0; i < N; i++) c[i] = (i < K) ? dsym(dv, i) : 0;
            for (int i = 0; i < K; i++) begin
                int q = c[i];
                for (int j = 0; j <= T2; j++) c[i+j] ^= fm(q, gl[T2-j]);
            end
            for (int i = K; i < N; i++)
                chk(got[i] == c[i], "R6 parity by long division", got[i], c[i]);
        end
    endtask

    initial begin
        int v;
        v = 1;
        for (int i = 0; i < 2 * N; i++) begin
            exp_t[i] = v;
            if (i < N) log_t[v] = i;
            v = v << 1;
            if ((v & (1 << M)) != 0) v ^= POLY;
        end
        log_t[0] = 0;
    end

    initial begin
        int nout, nlow, fcyc;
        bit lastok;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 0, "R10 reset out_valid", int'(out_valid), 0);
        chk(in_ready == 1, "R10 reset in_ready", int'(in_ready), 1);
        rst = 0;

        for (int t = 0; t < NV; t++) begin
            int hv = int'(VEC[t][M*(K+1)-1 -: M]);
            run_block(hv, VEC[t][M*K-1:0], t[0], 0, 0, nout, nlow, fcyc, lastok);
            verify(hv, VEC[t][M*K-1:0], nout, nlow, fcyc, lastok);
        end

        // R7: h_sel wanders after the first symbol
        run_block(3, 15'o62514, 0, 1, 0, nout, nlow, fcyc, lastok);
        verify(3, 15'o62514, nout, nlow, fcyc, lastok);

        // R9: stray start flag on the third symbol
        run_block(5, 15'o34021, 0, 0, 1, nout, nlow, fcyc, lastok);
        chk(nout == N, "R9 block not restarted", nout, N);
        verify(5, 15'o34021, nout, nlow, fcyc, lastok);

        // R8: idle symbols without a start flag
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(out_valid == 0, "R8 idle symbol discarded", int'(out_valid), 0);
            in_valid = 1; in_sob = 0; in_sym = M'(i + 4);
        end
        @(negedge clk);
        in_valid = 0;
        for (int i = 0; i < 3; i++) begin
            chk(out_valid == 0, "R8 idle symbol discarded", int'(out_valid), 0);
            @(negedge clk);
        end
        run_block(2, 15'o71263, 1, 0, 0, nout, nlow, fcyc, lastok);
        verify(2, 15'o71263, nout, nlow, fcyc, lastok);

        // R11: h = n equals h = 0
        run_block(N, 15'o43217, 0, 0, 0, nout, nlow, fcyc, lastok);
        verify(N, 15'o43217, nout, nlow, fcyc, lastok);
        for (int i = 0; i < N; i++) keep[i] = got[i];
        run_block(0, 15'o43217, 0, 0, 0, nout, nlow, fcyc, lastok);
        for (int i = 0; i < N; i++)
            chk(got[i] == keep[i], "R11 h=n matches h=0", keep[i], got[i]);

        // R10: reset in the middle of a block
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_valid = 1; in_sob = (i == 0); in_sym = M'(i + 1); h_sel = M'(4);
        end
        @(negedge clk);
        in_valid = 0; in_sob = 0;
        rst = 1;
        @(negedge clk);
        chk(out_valid == 0, "R10 mid-block reset out_valid", int'(out_valid), 0);
        chk(in_ready == 1, "R10 mid-block reset in_ready", int'(in_ready), 1);
        rst = 0;
        run_block(4, 15'o12121, 0, 0, 0, nout, nlow, fcyc, lastok);
        verify(4, 15'o12121, nout, nlow, fcyc, lastok);

        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule